// File: doc/BRIEF.md
# Subcode Serial Receiver with Q-Channel Extractor

This block takes the subcode line from a disc decoder, a serial stream whose bit clock is not tied to the local clock. It recovers each bit by counting system clocks at a nominal 24 clocks per bit. It detects the long marker that opens every subcode sector and writes each received symbol to a buffer manager as a byte. Alongside that, it gathers the Q bit of every symbol into Q-channel bytes and writes those too. It checks the Q-channel CRC and follows the last Q byte with a one-byte sector status.

Five Q fields (mode/control, track, minutes, seconds, frames) are held in registers for firmware. A ready flag says when they are current. An interrupt is raised either by that flag or, in audio operation, by an external header-ready event.

Line format: idle low, then per symbol a start bit of 1, seven data bits (Q first, W last) and a stop bit of 0. A sector is opened by the line staying high for a long run. The sector then carries two sync symbols and 96 data symbols, which give 12 Q bytes. Bytes 10 and 11 hold the CRC.

Top module: `subq_receiver`

## Requirements
- R1: A symbol begins on a rising edge of the synchronised line. Each of its 9 bit slots (start, Q, R, S, T, U, V, W, stop) is sampled BIT_CLKS/2 clocks into the slot. Slots are counted from that edge at BIT_CLKS clocks each. A start slot sampled low or a stop slot sampled high discards the symbol. Bit periods of 23 to 25 clocks are received correctly at BIT_CLKS=24.
- R2: A high run on the line of SYNC_BITS*BIT_CLKS clocks produces exactly one single-cycle `sect_start` pulse and opens a sector. The next two symbols are sync symbols and are not written. The 96 symbols after them are data symbols.
- R3: Each data symbol is written with `wr_kind`=0 and `wr_data` = {0,Q,R,S,T,U,V,W}, so bit 7 is 0 and Q sits in bit 6.
- R4: The Q bits of each run of 8 data symbols form one Q byte, first-received bit in bit 7. It is written with `wr_kind`=1 in the cycle after the write of the eighth symbol.
- R5: Symbols received before the first sector marker, and symbols after the 98th symbol of a sector, produce no write.
- R6: The Q CRC is x^16+x^12+x^5+1 with a zero start value, taken MSB-first over the first 80 Q bits. Q bytes 10 and 11 must equal the complement of its high and low byte. After Q byte 11 is written, a status byte follows the next cycle with `wr_kind`=2 and data bit 0 = 1 on mismatch (other bits 0). `bad_q` shows the same result until the next sector marker.
- R7: `q_mode`, `q_track`, `q_min`, `q_sec` and `q_frame` take Q bytes 0, 1, 3, 4 and 5 of the sector. `qfrm_ready` rises once all five have been taken in the current sector.
- R8: `qfrm_ready` is cleared by `sect_start` and by a one-cycle `frm_rd` pulse.
- R9: With `audio_mode`=0, `irq` pulses for one cycle when `qfrm_ready` is set. With `audio_mode`=1, `irq` pulses one cycle after each `hdr_rdy` pulse and never for `qfrm_ready`.
- R10: While reset is asserted, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sc_in | input | 1 | Serial subcode line, asynchronous |
| audio_mode | input | 1 | Selects header-ready as interrupt source |
| hdr_rdy | input | 1 | Header-ready event pulse |
| frm_rd | input | 1 | Firmware read of the frame register, clears the ready flag |
| sect_start | output | 1 | Pulse at each detected sector marker |
| wr_stb | output | 1 | Buffer write strobe, one cycle per byte |
| wr_kind | output | 2 | 0 symbol byte, 1 Q byte, 2 status byte |
| wr_data | output | 8 | Byte to be written |
| q_mode | output | 8 | Q byte 0 (control and mode) |
| q_track | output | 8 | Q byte 1 (track) |
| q_min | output | 8 | Q byte 3 (minutes) |
| q_sec | output | 8 | Q byte 4 (seconds) |
| q_frame | output | 8 | Q byte 5 (frames) |
| qfrm_ready | output | 1 | Q field registers are current |
| bad_q | output | 1 | Q CRC mismatch in the last sector |
| irq | output | 1 | Interrupt pulse |

## Verification
The bench builds the block with its defaults: 24 clocks per bit, a 10-bit sector marker, 2 sync and 96 data symbols. The data-symbol R..W field walks all 64 values in each sector under varying Q bits, so every symbol byte pattern is packed and written. One sector is sent with bit periods alternating 23 and 25 clocks, which brings the sampling-point margin within reach. Sectors with a correct and a corrupted Q CRC, a runt pulse, symbols outside a sector, and the switch to header-driven interrupts cover the remaining paths.

// File: rtl/subq_pkg.sv
package subq_pkg;

  typedef enum logic [1:0] {
    WK_SYM   = 2'd0,
    WK_QBYTE = 2'd1,
    WK_STAT  = 2'd2
  } wr_kind_e;

  localparam int N_FIELDS = 5;
  // Q byte position of each firmware field: mode, track, min, sec, frame
  localparam int FIELD_POS [N_FIELDS] = '{0, 1, 3, 4, 5};

  localparam logic [15:0] QCRC_POLY = 16'h1021;

  function automatic logic [15:0] qcrc_step(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[15] ^ b;
    return {c[14:0], 1'b0} ^ (fb ? QCRC_POLY : 16'h0000);
  endfunction

endpackage

// File: rtl/subq_syncdet.sv
module subq_syncdet #(
  parameter int BIT_CLKS  = 24,
  parameter int SYNC_BITS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_s,
  output logic sync_pulse
);

  localparam int SYNC_CLKS = BIT_CLKS * SYNC_BITS;
  localparam int RW        = $clog2(SYNC_CLKS + 1);

  logic [RW-1:0] run_q, run_n;
  logic          sync_n;

  always_comb begin
    run_n  = run_q;
    sync_n = 1'b0;
    if (!rx_s) begin
      run_n = '0;
    end else if (run_q != RW'(SYNC_CLKS)) begin
      run_n = run_q + 1'b1;
      if (run_q == RW'(SYNC_CLKS - 1)) sync_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= '0;
      sync_pulse <= 1'b0;
    end else begin
      run_q      <= run_n;
      sync_pulse <= sync_n;
    end
  end

  assert_sync_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |=> !sync_pulse);

  assert_sync_line_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |-> $past(rx_s));

endmodule

// File: rtl/subq_bitrx.sv
module subq_bitrx #(
  parameter int BIT_CLKS  = 24,
  parameter int DATA_BITS = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_s,
  input  logic                 abort,
  output logic                 sym_vld,
  output logic [DATA_BITS-1:0] sym_data
);

  localparam int HALF     = BIT_CLKS / 2;
  localparam int CW       = $clog2(BIT_CLKS);
  localparam int STOP_IDX = DATA_BITS + 1;
  localparam int NW       = $clog2(STOP_IDX + 1);

  typedef enum logic [1:0] {RX_IDLE, RX_RUN, RX_HOLD} rx_st_e;

  rx_st_e               st_q, st_n;
  logic [CW-1:0]        cnt_q, cnt_n;
  logic [NW-1:0]        slot_q, slot_n;
  logic [DATA_BITS-1:0] sh_q, sh_n;
  logic                 prev_q;
  logic                 vld_n;

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    slot_n = slot_q;
    sh_n   = sh_q;
    vld_n  = 1'b0;
    unique case (st_q)
      RX_IDLE: begin
        if (rx_s && !prev_q) begin
          st_n   = RX_RUN;
          cnt_n  = '0;
          slot_n = '0;
        end
      end
      RX_RUN: begin
        if (cnt_q == CW'(BIT_CLKS - 1)) begin
          cnt_n  = '0;
          slot_n = slot_q + 1'b1;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
        if (cnt_q == CW'(HALF)) begin
          if (slot_q == '0) begin
            if (!rx_s) st_n = RX_IDLE;
          end else if (slot_q == NW'(STOP_IDX)) begin
            if (!rx_s) begin
              vld_n = 1'b1;
              st_n  = RX_IDLE;
            end else begin
              st_n = RX_HOLD;
            end
          end else begin
            sh_n = {sh_q[DATA_BITS-2:0], rx_s};
          end
        end
      end
      default: begin
        if (!rx_s) st_n = RX_IDLE;
      end
    endcase
    if (abort) begin
      st_n  = RX_HOLD;
      vld_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RX_IDLE;
      cnt_q   <= '0;
      slot_q  <= '0;
      sh_q    <= '0;
      prev_q  <= 1'b0;
      sym_vld <= 1'b0;
    end else begin
      st_q    <= st_n;
      cnt_q   <= cnt_n;
      slot_q  <= slot_n;
      sh_q    <= sh_n;
      prev_q  <= rx_s;
      sym_vld <= vld_n;
    end
  end

  assign sym_data = sh_q;

  assert_stop_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sym_vld |-> $past(!rx_s));

  assert_slot_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RX_RUN) |-> (slot_q <= NW'(STOP_IDX)));

  assert_abort_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !sym_vld);

endmodule

// File: rtl/subq_sector.sv
module subq_sector
  import subq_pkg::*;
#(
  parameter int SYNC_SYMS = 2,
  parameter int DATA_SYMS = 96
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sync_pulse,
  input  logic                    sym_vld,
  input  logic [6:0]              sym_data,
  input  logic                    audio_mode,
  input  logic                    hdr_rdy,
  input  logic                    frm_rd,
  output logic                    wr_stb,
  output logic [1:0]              wr_kind,
  output logic [7:0]              wr_data,
  output logic [N_FIELDS*8-1:0]   fields,
  output logic                    qfrm_ready,
  output logic                    bad_q,
  output logic                    irq
);

  localparam int TOTAL_SYMS = SYNC_SYMS + DATA_SYMS;
  localparam int Q_BYTES    = DATA_SYMS / 8;
  localparam int CRC_HI     = Q_BYTES - 2;
  localparam int CRC_LO     = Q_BYTES - 1;
  localparam int IW         = $clog2(TOTAL_SYMS + 1);
  localparam int QW         = $clog2(Q_BYTES + 1);

  logic                  in_sec_q, in_sec_n;
  logic [IW-1:0]         idx_q, idx_n;
  logic [7:0]            qsh_q, qsh_n;
  logic [2:0]            qcnt_q, qcnt_n;
  logic [QW-1:0]         qbi_q, qbi_n;
  logic [15:0]           crc_q, crc_n;
  logic [7:0]            crx_q, crx_n;
  logic                  pq_q, pq_n;
  logic [7:0]            pqd_q, pqd_n;
  logic                  ps_q, ps_n;
  logic                  bad_n;
  logic                  rdy_n;
  logic [N_FIELDS-1:0]   mask_q, mask_n;
  logic [N_FIELDS*8-1:0] fld_n;
  logic                  stb_n;
  wr_kind_e              kind_q, kind_n;
  logic [7:0]            data_n;
  logic                  irq_n;
  logic                  accept, is_data, set_rdy;

  always_comb begin
    in_sec_n = in_sec_q;
    idx_n    = idx_q;
    qsh_n    = qsh_q;
    qcnt_n   = qcnt_q;
    qbi_n    = qbi_q;
    crc_n    = crc_q;
    crx_n    = crx_q;
    pq_n     = pq_q;
    pqd_n    = pqd_q;
    ps_n     = ps_q;
    bad_n    = bad_q;
    rdy_n    = qfrm_ready;
    mask_n   = mask_q;
    fld_n    = fields;
    stb_n    = 1'b0;
    kind_n   = WK_SYM;
    data_n   = 8'h00;
    set_rdy  = 1'b0;

    accept  = sym_vld && in_sec_q && (idx_q != IW'(TOTAL_SYMS));
    is_data = idx_q >= IW'(SYNC_SYMS);

    if (frm_rd) rdy_n = 1'b0;

    if (sync_pulse) begin
      in_sec_n = 1'b1;
      idx_n    = '0;
      qcnt_n   = '0;
      qbi_n    = '0;
      crc_n    = '0;
      pq_n     = 1'b0;
      ps_n     = 1'b0;
      bad_n    = 1'b0;
      rdy_n    = 1'b0;
      mask_n   = '0;
    end else if (accept) begin
      idx_n = idx_q + 1'b1;
      if (is_data) begin
        stb_n  = 1'b1;
        kind_n = WK_SYM;
        data_n = {1'b0, sym_data};
        qsh_n  = {qsh_q[6:0], sym_data[6]};
        qcnt_n = qcnt_q + 1'b1;
        if (qbi_q < QW'(CRC_HI)) crc_n = qcrc_step(crc_q, sym_data[6]);
        if (qcnt_q == 3'd7) begin
          pq_n  = 1'b1;
          pqd_n = qsh_n;
          qbi_n = qbi_q + 1'b1;
          for (int f = 0; f < N_FIELDS; f++) begin
            if (qbi_q == QW'(FIELD_POS[f])) begin
              fld_n[f*8 +: 8] = qsh_n;
              mask_n[f]       = 1'b1;
            end
          end
          if ((&mask_n) && !(&mask_q)) set_rdy = 1'b1;
          if (qbi_q == QW'(CRC_HI)) crx_n = qsh_n;
          if (qbi_q == QW'(CRC_LO)) begin
            bad_n = (crc_q != ~{crx_q, qsh_n});
            ps_n  = 1'b1;
          end
        end
      end
    end else if (pq_q) begin
      stb_n  = 1'b1;
      kind_n = WK_QBYTE;
      data_n = pqd_q;
      pq_n   = 1'b0;
    end else if (ps_q) begin
      stb_n  = 1'b1;
      kind_n = WK_STAT;
      data_n = {7'b0, bad_q};
      ps_n   = 1'b0;
    end

    if (set_rdy) rdy_n = 1'b1;
    irq_n = audio_mode ? hdr_rdy : set_rdy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_sec_q   <= 1'b0;
      idx_q      <= '0;
      qsh_q      <= '0;
      qcnt_q     <= '0;
      qbi_q      <= '0;
      crc_q      <= '0;
      crx_q      <= '0;
      pq_q       <= 1'b0;
      pqd_q      <= '0;
      ps_q       <= 1'b0;
      bad_q      <= 1'b0;
      qfrm_ready <= 1'b0;
      mask_q     <= '0;
      fields     <= '0;
      wr_stb     <= 1'b0;
      kind_q     <= WK_SYM;
      wr_data    <= '0;
      irq        <= 1'b0;
    end else begin
      in_sec_q   <= in_sec_n;
      idx_q      <= idx_n;
      qsh_q      <= qsh_n;
      qcnt_q     <= qcnt_n;
      qbi_q      <= qbi_n;
      crc_q      <= crc_n;
      crx_q      <= crx_n;
      pq_q       <= pq_n;
      pqd_q      <= pqd_n;
      ps_q       <= ps_n;
      bad_q      <= bad_n;
      qfrm_ready <= rdy_n;
      mask_q     <= mask_n;
      fields     <= fld_n;
      wr_stb     <= stb_n;
      kind_q     <= kind_n;
      wr_data    <= data_n;
      irq        <= irq_n;
    end
  end

  assign wr_kind = kind_q;

  assert_qbyte_follows_sym_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && kind_q == WK_QBYTE) |-> $past(wr_stb && kind_q == WK_SYM));

  assert_stat_follows_q_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && kind_q == WK_STAT) |-> $past(wr_stb && kind_q == WK_QBYTE));

  assert_ready_needs_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qfrm_ready) |-> (&mask_q));

  assert_sync_clears_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |=> !qfrm_ready);

  assert_audio_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (audio_mode && hdr_rdy) |=> irq);

  assert_index_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IW'(TOTAL_SYMS));

  assert_sync_sym_apart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(sync_pulse && sym_vld));

endmodule

// File: rtl/subq_receiver.sv
module subq_receiver
  import subq_pkg::*;
#(
  parameter int BIT_CLKS  = 24,
  parameter int SYNC_BITS = 10,
  parameter int SYNC_SYMS = 2,
  parameter int DATA_SYMS = 96
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sc_in,
  input  logic       audio_mode,
  input  logic       hdr_rdy,
  input  logic       frm_rd,
  output logic       sect_start,
  output logic       wr_stb,
  output logic [1:0] wr_kind,
  output logic [7:0] wr_data,
  output logic [7:0] q_mode,
  output logic [7:0] q_track,
  output logic [7:0] q_min,
  output logic [7:0] q_sec,
  output logic [7:0] q_frame,
  output logic       qfrm_ready,
  output logic       bad_q,
  output logic       irq
);

  logic                  rst_meta, rst_i;
  logic                  rx_meta, rx_s;
  logic                  sym_vld;
  logic [6:0]            sym_data;
  logic [N_FIELDS*8-1:0] fields;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_i    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_i    <= rst_meta;
    end
  end

  // two-stage synchroniser for the asynchronous serial line
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      rx_meta <= 1'b0;
      rx_s    <= 1'b0;
    end else begin
      rx_meta <= sc_in;
      rx_s    <= rx_meta;
    end
  end

  subq_syncdet #(.BIT_CLKS(BIT_CLKS), .SYNC_BITS(SYNC_BITS)) u_sync (
    .clk        (clk),
    .rst_n      (rst_i),
    .rx_s       (rx_s),
    .sync_pulse (sect_start)
  );

  subq_bitrx #(.BIT_CLKS(BIT_CLKS), .DATA_BITS(7)) u_bits (
    .clk      (clk),
    .rst_n    (rst_i),
    .rx_s     (rx_s),
    .abort    (sect_start),
    .sym_vld  (sym_vld),
    .sym_data (sym_data)
  );

  subq_sector #(.SYNC_SYMS(SYNC_SYMS), .DATA_SYMS(DATA_SYMS)) u_sect (
    .clk        (clk),
    .rst_n      (rst_i),
    .sync_pulse (sect_start),
    .sym_vld    (sym_vld),
    .sym_data   (sym_data),
    .audio_mode (audio_mode),
    .hdr_rdy    (hdr_rdy),
    .frm_rd     (frm_rd),
    .wr_stb     (wr_stb),
    .wr_kind    (wr_kind),
    .wr_data    (wr_data),
    .fields     (fields),
    .qfrm_ready (qfrm_ready),
    .bad_q      (bad_q),
    .irq        (irq)
  );

  assign q_mode  = fields[0*8 +: 8];
  assign q_track = fields[1*8 +: 8];
  assign q_min   = fields[2*8 +: 8];
  assign q_sec   = fields[3*8 +: 8];
  assign q_frame = fields[4*8 +: 8];

  assert_status_bit_only_R6: assert property (@(posedge clk) disable iff (!rst_i)
    (wr_stb && wr_kind == 2'd2) |-> (wr_data[7:1] == 7'd0));

endmodule

// File: tb/sim_subq_receiver.sv
module sim_subq_receiver;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sc_in, audio_mode, hdr_rdy, frm_rd;
  logic       sect_start, wr_stb, qfrm_ready, bad_q, irq;
  logic [1:0] wr_kind;
  logic [7:0] wr_data, q_mode, q_track, q_min, q_sec, q_frame;

  always #10 clk = ~clk;

  subq_receiver u0 (
    .clk(clk), .rst_n(rst_n), .sc_in(sc_in), .audio_mode(audio_mode),
    .hdr_rdy(hdr_rdy), .frm_rd(frm_rd), .sect_start(sect_start),
    .wr_stb(wr_stb), .wr_kind(wr_kind), .wr_data(wr_data),
    .q_mode(q_mode), .q_track(q_track), .q_min(q_min), .q_sec(q_sec),
    .q_frame(q_frame), .qfrm_ready(qfrm_ready), .bad_q(bad_q), .irq(irq)
  );

  int errors = 0;
  int checks = 0;
  int got_n = 0, exp_n = 0, cmp_n = 0;
  int irq_cnt = 0, sync_cnt = 0;
  logic [1:0] got_k [1024];
  logic [7:0] got_d [1024];
  logic [1:0] exp_k [1024];
  logic [7:0] exp_d [1024];
  logic [7:0] qb [12];

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_stb) begin
        if (got_n < 1024) begin
          got_k[got_n] = wr_kind;
          got_d[got_n] = wr_data;
        end
        got_n++;
      end
      if (irq) irq_cnt++;
      if (sect_start) sync_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_sym(input logic [6:0] v, input int per);
    sc_in = 1'b1; clks(per);
    for (int b = 6; b >= 0; b--) begin sc_in = v[b]; clks(per); end
    sc_in = 1'b0; clks(per);
  endtask

  task automatic send_marker();
    sc_in = 1'b1; clks(12 * 24);
    sc_in = 1'b0; clks(24);
  endtask

  function automatic logic [15:0] crc_of_q();
    logic [15:0] c = 16'h0000;
    for (int j = 0; j < 10; j++)
      for (int k = 7; k >= 0; k--) begin
        logic fb;
        fb = c[15] ^ qb[j][k];
        c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
      end
    return c;
  endfunction

  // sends sync symbols and data symbols; appends expected writes
  task automatic send_body(input int mul, input int add, input bit jitter, input bit bad_exp);
    send_sym(7'h00, 24);
    send_sym(7'h7F, 24);
    for (int i = 0; i < 96; i++) begin
      logic [6:0] s;
      s = {qb[i/8][7 - (i%8)], 6'((i * mul + add) & 63)};
      send_sym(s, jitter ? ((i % 2) ? 23 : 25) : 24);
      exp_k[exp_n] = 2'd0; exp_d[exp_n] = {1'b0, s}; exp_n++;
      if (i % 8 == 7) begin exp_k[exp_n] = 2'd1; exp_d[exp_n] = qb[i/8]; exp_n++; end
      if (i == 95) begin exp_k[exp_n] = 2'd2; exp_d[exp_n] = {7'b0, bad_exp}; exp_n++; end
    end
    clks(10);
  endtask

  task automatic compare_log();
    chk(got_n == exp_n, "R2 write count", got_n, exp_n);
    for (int j = cmp_n; j < exp_n && j < got_n; j++) begin
      string r;
      r = (exp_k[j] == 2'd0) ? "R3 symbol byte" : (exp_k[j] == 2'd1) ? "R4 Q byte" : "R6 status byte";
      chk(got_k[j] == exp_k[j], r, got_k[j], exp_k[j]);
      chk(got_d[j] == exp_d[j], r, got_d[j], exp_d[j]);
    end
    cmp_n = exp_n;
  endtask

  task automatic check_fields(input string tag);
    chk(q_mode  == qb[0], tag, q_mode,  qb[0]);
    chk(q_track == qb[1], tag, q_track, qb[1]);
    chk(q_min   == qb[3], tag, q_min,   qb[3]);
    chk(q_sec   == qb[4], tag, q_sec,   qb[4]);
    chk(q_frame == qb[5], tag, q_frame, qb[5]);
    chk(qfrm_ready == 1'b1, "R7 ready set", qfrm_ready, 1);
  endtask

  task automatic load_q(input logic [7:0] a, input logic [7:0] t, input logic [7:0] m,
                        input logic [7:0] s, input logic [7:0] f, input bit corrupt);
    logic [15:0] c;
    qb[0] = a; qb[1] = t; qb[2] = 8'h01; qb[3] = m; qb[4] = s; qb[5] = f;
    qb[6] = 8'h00; qb[7] = m ^ 8'h11; qb[8] = s ^ 8'h22; qb[9] = f ^ 8'h33;
    c = ~crc_of_q();
    qb[10] = c[15:8];
    qb[11] = corrupt ? (c[7:0] ^ 8'h04) : c[7:0];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int irq0;
    rst_n = 1'b0; sc_in = 1'b0; audio_mode = 1'b0; hdr_rdy = 1'b0; frm_rd = 1'b0;
    clks(5);
    // R10 reset state
    chk({sect_start, wr_stb, wr_kind, wr_data, qfrm_ready, bad_q, irq} == '0, "R10 reset outputs", wr_data, 0);
    chk({q_mode, q_track, q_min, q_sec, q_frame} == '0, "R10 reset fields", q_mode, 0);
    rst_n = 1'b1;
    clks(10);

    // R5: symbol before any sector marker; R1: runt high pulse
    send_sym(7'h5A, 24);
    sc_in = 1'b1; clks(5); sc_in = 1'b0; clks(60);
    chk(got_n == 0, "R5 pre-sector symbol ignored", got_n, 0);
    chk(got_n == 0, "R1 runt start discarded", got_n, 0);

    // sector 1: good CRC, data-mode interrupt
    load_q(8'h41, 8'h05, 8'h02, 8'h34, 8'h56, 1'b0);
    send_marker();
    chk(sync_cnt == 1, "R2 one marker pulse", sync_cnt, 1);
    send_body(1, 0, 1'b0, 1'b0);
    compare_log();
    check_fields("R7 field sector1");
    chk(bad_q == 1'b0, "R6 good crc", bad_q, 0);
    chk(irq_cnt == 1, "R9 data-mode irq", irq_cnt, 1);
    frm_rd = 1'b1; clks(1); frm_rd = 1'b0; clks(2);
    chk(qfrm_ready == 1'b0, "R8 read clears ready", qfrm_ready, 0);

    // sector 2: corrupted CRC, bit periods of 23 and 25 clocks
    load_q(8'h01, 8'h12, 8'h59, 8'h07, 8'h74, 1'b1);
    send_marker();
    send_body(7, 11, 1'b1, 1'b1);
    compare_log();
    check_fields("R1 jittered fields");
    chk(bad_q == 1'b1, "R6 bad crc flag", bad_q, 1);
    chk(irq_cnt == 2, "R9 second irq", irq_cnt, 2);
    // R5: symbols beyond the 98th
    for (int e = 0; e < 3; e++) send_sym(7'(e * 19 + 3), 24);
    clks(5);
    chk(got_n == exp_n, "R5 extra symbols ignored", got_n, exp_n);

    // sector 3: marker clears ready; audio mode uses header event
    chk(qfrm_ready == 1'b1, "R7 ready held", qfrm_ready, 1);
    audio_mode = 1'b1;
    irq0 = irq_cnt;
    send_marker();
    chk(qfrm_ready == 1'b0, "R8 marker clears ready", qfrm_ready, 0);
    chk(bad_q == 1'b0, "R6 bad cleared by marker", bad_q, 0);
    hdr_rdy = 1'b1; clks(1); hdr_rdy = 1'b0; clks(3);
    chk(irq_cnt == irq0 + 1, "R9 header irq", irq_cnt, irq0 + 1);
    load_q(8'h42, 8'h63, 8'h10, 8'h20, 8'h30, 1'b0);
    send_body(3, 40, 1'b0, 1'b0);
    compare_log();
    check_fields("R7 field sector3");
    chk(irq_cnt == irq0 + 1, "R9 no ready irq in audio", irq_cnt, irq0 + 1);
    chk(sync_cnt == 3, "R2 marker count", sync_cnt, 3);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule